// File: doc/BRIEF.md
# Per-Thread Critical Read Nominator

This block keeps a record of every outstanding read in a shared read queue, grouped by the thread that issued it. It treats the oldest outstanding read of each thread as the request that most likely holds up that thread's reorder-buffer head. The processor does not need to send any head information. A bank scheduler that is about to open a row on a closed bank queries the block with the bank number. The block answers with a single nominee: the head read of one thread that targets that bank. This nominee outranks every other activation candidate the bank might pick.

Reads enter through an insert event that carries the queue slot, the thread, the target bank and an arrival stamp. They leave through a retire event that carries the queue slot. Nominations are made only while the controller is in read-priority mode and the queried bank has no open row. When several threads qualify, the block rotates among them. When the scheduler accepts a nominee, it pulses a take input. That request is then in service and stops counting as its thread's nominee. If nothing qualifies, the valid output stays low and the bank uses its default choice.

Top module: `crit_req_selector`

## Requirements
- R1: During and directly after a synchronous active-low reset, no thread has a head request and `nom_valid` is 0.
- R2: Each thread's head request is its valid entry with the oldest arrival stamp. Stamps are compared modulo 2^STAMP_W, and the smaller one is the older. Only a thread's head can be nominated.
- R3: A nominee is given only when `qry_en` is 1, the head's bank equals `qry_bank`, and `qry_row_open` is 0.
- R4: When `read_mode` is 0, `nom_valid` is 0 whatever the other inputs are.
- R5: Among threads with an eligible head, the grant goes to the first thread at or after the rotation pointer, in increasing thread number with wrap-around. A take (`nom_take`=1 while `nom_valid`=1) moves the pointer to the thread after the granted one.
- R6: After a take, that thread's head is in service. It is not nominated again, and the thread's younger reads are not nominated, until that head retires.
- R7: When a thread's head retires, the next-oldest remaining read of that thread becomes its head on the next cycle. If no read remains, the thread has no head.
- R8: A read inserted into a thread that has no head becomes that thread's head from the next cycle. It is not nominated in the cycle of its insertion.
- R9: If a thread's head retires in the same cycle as a new read of that thread is inserted, the new head is the oldest of the remaining reads and the new one.
- R10: `nom_thread` gives the thread of the nominee, and `nom_idx` gives its read-queue slot.
- R11: When no thread has an eligible head, `nom_valid` is 0.
- R12: Without a take, the rotation pointer holds. Repeated queries with the same state return the same nominee.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_en | input | 1 | Insert a read this cycle |
| ins_idx | input | IDX_W (6) | Read-queue slot of the inserted read |
| ins_thread | input | THR_W (2) | Issuing thread of the inserted read |
| ins_bank | input | BANK_W (3) | Target bank of the inserted read |
| ins_stamp | input | STAMP_W (16) | Arrival stamp; later reads carry larger values |
| ret_en | input | 1 | Retire a read this cycle |
| ret_idx | input | IDX_W (6) | Read-queue slot being retired |
| read_mode | input | 1 | 1 when the controller favours reads |
| qry_en | input | 1 | A bank asks for a nominee |
| qry_bank | input | BANK_W (3) | Bank being asked about |
| qry_row_open | input | 1 | The queried bank currently holds an open row |
| nom_take | input | 1 | The presented nominee is accepted for activation |
| nom_valid | output | 1 | A nominee is presented |
| nom_idx | output | IDX_W (6) | Read-queue slot of the nominee |
| nom_thread | output | THR_W (2) | Thread of the nominee |

## Verification
The hard case is a head retirement and an insertion for the same thread in one cycle. Two paths then decide the thread's next head together: the search for the next-oldest remaining read and the capture of the newly inserted one. The bench sets up this case twice. Once the thread still holds an older read, so that read must win. Once the thread is otherwise empty, so the new read must take over. Each time, the following query is compared with the scoreboard's expected slot and thread. A grant arriving right after these moves also shows that the rotation pointer and the in-service marking stay consistent with the new heads.

// File: rtl/crs_pkg.sv
// Package: default sizing shared by the nominator and its sub-blocks.
// Assumes: thread count and queue depth are powers of two.
package crs_pkg;
    localparam int unsigned CRS_THREADS = 4;
    localparam int unsigned CRS_DEPTH   = 64;
    localparam int unsigned CRS_BANKS   = 8;
    localparam int unsigned CRS_STAMP_W = 16;
endpackage

// File: rtl/cr_oldest_finder.sv
// Module: cr_oldest_finder
// Finds the oldest live entry of one thread, skipping one slot (the one
// being retired), with an optional extra candidate (a same-cycle insert).
// Assumes: stamps wrap modulo 2^STAMP_W and live stamps of one thread span
// less than half that range.
module cr_oldest_finder #(
    parameter int DEPTH   = 64,
    parameter int THREADS = 4,
    parameter int STAMP_W = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int THR_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic [DEPTH-1:0]   live,
    input  logic [THR_W-1:0]   thr   [DEPTH],
    input  logic [STAMP_W-1:0] stamp [DEPTH],
    input  logic [THR_W-1:0]   sel_thr,
    input  logic [IDX_W-1:0]   skip_idx,
    input  logic               extra_en,
    input  logic [IDX_W-1:0]   extra_idx,
    input  logic [STAMP_W-1:0] extra_stamp,
    output logic               found,
    output logic [IDX_W-1:0]   found_idx
);
    // Linear minimum search over all candidates of the selected thread.
    always_comb begin
        logic [STAMP_W-1:0] best;
        logic [STAMP_W-1:0] diff;
        found     = extra_en;
        found_idx = extra_idx;
        best      = extra_stamp;
        diff      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            diff = stamp[i] - best;
            if (live[i] && thr[i] == sel_thr && IDX_W'(i) != skip_idx &&
                (!found || diff[STAMP_W-1])) begin
                found     = 1'b1;
                found_idx = IDX_W'(i);
                best      = stamp[i];
            end
        end
    end
endmodule

// File: rtl/cr_entry_table.sv
// Module: cr_entry_table
// Holds thread, bank, stamp and in-service flag for each read-queue slot and
// a registered head pointer per thread (its oldest outstanding read).
// Assumes: no insert into a live slot, no insert and retire of one slot in
// the same cycle, and stamps that grow with arrival.
module cr_entry_table #(
    parameter int THREADS = 4,
    parameter int DEPTH   = 64,
    parameter int BANKS   = 8,
    parameter int STAMP_W = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int THR_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_en,
    input  logic [IDX_W-1:0]   ins_idx,
    input  logic [THR_W-1:0]   ins_thr,
    input  logic [BANK_W-1:0]  ins_bank,
    input  logic [STAMP_W-1:0] ins_stamp,
    input  logic               ret_en,
    input  logic [IDX_W-1:0]   ret_idx,
    input  logic               gnt_en,
    input  logic [IDX_W-1:0]   gnt_idx,
    output logic               head_valid [THREADS],
    output logic [IDX_W-1:0]   head_idx   [THREADS],
    output logic [BANK_W-1:0]  head_bank  [THREADS],
    output logic               head_busy  [THREADS]
);
    logic [DEPTH-1:0]   ent_v;
    logic [DEPTH-1:0]   ent_busy;
    logic [THR_W-1:0]   ent_thr   [DEPTH];
    logic [BANK_W-1:0]  ent_bank  [DEPTH];
    logic [STAMP_W-1:0] ent_stamp [DEPTH];
    logic               hd_v      [THREADS];
    logic [IDX_W-1:0]   hd_idx    [THREADS];

    logic               fnd_v;
    logic [IDX_W-1:0]   fnd_idx;
    logic [THR_W-1:0]   ret_thr;

    // Occupancy and in-service flags; a retire wins over a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v    <= '0;
            ent_busy <= '0;
        end else begin
            if (ins_en) begin
                ent_v[ins_idx]    <= 1'b1;
                ent_busy[ins_idx] <= 1'b0;
            end
            if (gnt_en) ent_busy[gnt_idx] <= 1'b1;
            if (ret_en) begin
                ent_v[ret_idx]    <= 1'b0;
                ent_busy[ret_idx] <= 1'b0;
            end
        end
    end

    // Payload capture on insert; payload of empty slots is don't-care.
    always_ff @(posedge clk) begin
        if (ins_en) begin
            ent_thr[ins_idx]   <= ins_thr;
            ent_bank[ins_idx]  <= ins_bank;
            ent_stamp[ins_idx] <= ins_stamp;
        end
    end

    assign ret_thr = ent_thr[ret_idx];

    cr_oldest_finder #(
        .DEPTH(DEPTH), .THREADS(THREADS), .STAMP_W(STAMP_W)
    ) u_finder (
        .live        (ent_v),
        .thr         (ent_thr),
        .stamp       (ent_stamp),
        .sel_thr     (ret_thr),
        .skip_idx    (ret_idx),
        .extra_en    (ins_en && ins_thr == ret_thr),
        .extra_idx   (ins_idx),
        .extra_stamp (ins_stamp),
        .found       (fnd_v),
        .found_idx   (fnd_idx)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_head
        logic [STAMP_W-1:0] ins_diff;
        logic               mine;
        assign ins_diff = ins_stamp - ent_stamp[hd_idx[t]];
        assign mine     = ins_en && ins_thr == THR_W'(t);

        // Head pointer: moves on head retire, captures older or first insert.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hd_v[t]   <= 1'b0;
                hd_idx[t] <= '0;
            end else if (ret_en && hd_v[t] && hd_idx[t] == ret_idx) begin
                hd_v[t]   <= fnd_v;
                hd_idx[t] <= fnd_idx;
            end else if (mine && (!hd_v[t] || ins_diff[STAMP_W-1])) begin
                hd_v[t]   <= 1'b1;
                hd_idx[t] <= ins_idx;
            end
        end

        assign head_valid[t] = hd_v[t];
        assign head_idx[t]   = hd_idx[t];
        assign head_bank[t]  = ent_bank[hd_idx[t]];
        assign head_busy[t]  = ent_busy[hd_idx[t]];

        // A head always points at a live slot owned by its thread.
        p_head_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hd_v[t] |-> (ent_v[hd_idx[t]] && ent_thr[hd_idx[t]] == THR_W'(t)));
    end
endmodule

// File: rtl/cr_rr_arbiter.sv
// Module: cr_rr_arbiter
// Round-robin pick among N requesters starting at a rotating pointer; the
// pointer moves past the winner only when the grant is consumed.
// Assumes: N is at least 2.
module cr_rr_arbiter #(
    parameter int N      = 4,
    localparam int ID_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic            adv,
    output logic            gnt_valid,
    output logic [ID_W-1:0] gnt_id
);
    logic [ID_W-1:0] ptr;

    // Nearest requester at or after the pointer wins.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_id    = ptr;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (req[j]) begin
                gnt_valid = 1'b1;
                gnt_id    = ID_W'(j);
            end
        end
    end

    // Pointer advance on a consumed grant.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= '0;
        else if (adv && gnt_valid) ptr <= (int'(gnt_id) == N - 1) ? '0 : gnt_id + 1'b1;
    end

    p_gnt_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_id]);
    p_ptr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && gnt_valid) |=> $stable(ptr));
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !gnt_valid);
endmodule

// File: rtl/crit_req_selector.sv
// Module: crit_req_selector (top)
// Nominates, for a queried closed bank in read-priority mode, the oldest
// outstanding read of one thread, rotating fairly among qualifying threads.
// Assumes: the caller pulses nom_take only while nom_valid is shown.
module crit_req_selector
    import crs_pkg::*;
#(
    parameter int THREADS = CRS_THREADS,
    parameter int DEPTH   = CRS_DEPTH,
    parameter int BANKS   = CRS_BANKS,
    parameter int STAMP_W = CRS_STAMP_W,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int THR_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_en,
    input  logic [IDX_W-1:0]   ins_idx,
    input  logic [THR_W-1:0]   ins_thread,
    input  logic [BANK_W-1:0]  ins_bank,
    input  logic [STAMP_W-1:0] ins_stamp,
    input  logic               ret_en,
    input  logic [IDX_W-1:0]   ret_idx,
    input  logic               read_mode,
    input  logic               qry_en,
    input  logic [BANK_W-1:0]  qry_bank,
    input  logic               qry_row_open,
    input  logic               nom_take,
    output logic               nom_valid,
    output logic [IDX_W-1:0]   nom_idx,
    output logic [THR_W-1:0]   nom_thread
);
    logic               head_valid [THREADS];
    logic [IDX_W-1:0]   head_idx   [THREADS];
    logic [BANK_W-1:0]  head_bank  [THREADS];
    logic               head_busy  [THREADS];
    logic [THREADS-1:0] eligible;
    logic               taken;

    assign taken = nom_take && nom_valid;

    cr_entry_table #(
        .THREADS(THREADS), .DEPTH(DEPTH), .BANKS(BANKS), .STAMP_W(STAMP_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_en     (ins_en),
        .ins_idx    (ins_idx),
        .ins_thr    (ins_thread),
        .ins_bank   (ins_bank),
        .ins_stamp  (ins_stamp),
        .ret_en     (ret_en),
        .ret_idx    (ret_idx),
        .gnt_en     (taken),
        .gnt_idx    (nom_idx),
        .head_valid (head_valid),
        .head_idx   (head_idx),
        .head_bank  (head_bank),
        .head_busy  (head_busy)
    );

    // Eligibility: read mode, closed queried bank, idle head on that bank.
    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            eligible[t] = qry_en && read_mode && !qry_row_open &&
                          head_valid[t] && !head_busy[t] &&
                          head_bank[t] == qry_bank;
        end
    end

    cr_rr_arbiter #(.N(THREADS)) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (eligible),
        .adv       (nom_take),
        .gnt_valid (nom_valid),
        .gnt_id    (nom_thread)
    );

    assign nom_idx = head_idx[nom_thread];

    p_read_mode_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !read_mode |-> !nom_valid);
    p_bank_closed_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nom_valid |-> (head_bank[nom_thread] == qry_bank && !qry_row_open));
    p_not_in_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nom_valid |-> !head_busy[nom_thread]);
    p_taken_marks_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !(ret_en && ret_idx == nom_idx)) |=> head_busy[$past(nom_thread)]);
endmodule

// File: tb/crit_req_selector_test.sv
// Scoreboard bench: driver tasks push expected nominations into a queue,
// a monitor at the falling edge pops and compares them with the outputs.
module crit_req_selector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_en = 1'b0;
    logic [5:0] ins_idx = '0;
    logic [1:0] ins_thread = '0;
    logic [2:0] ins_bank = '0;
    logic [15:0] ins_stamp = '0;
    logic       ret_en = 1'b0;
    logic [5:0] ret_idx = '0;
    logic       read_mode = 1'b1;
    logic       qry_en = 1'b0;
    logic [2:0] qry_bank = '0;
    logic       qry_row_open = 1'b0;
    logic       nom_take = 1'b0;
    logic       nom_valid;
    logic [5:0] nom_idx;
    logic [1:0] nom_thread;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    typedef struct {
        logic       v;
        logic [5:0] idx;
        logic [1:0] thr;
        string      tag;
    } exp_t;
    exp_t sb[$];
    exp_t cur;

    always #2.5 clk = ~clk;

    crit_req_selector uut (
        .clk(clk), .rst_n(rst_n),
        .ins_en(ins_en), .ins_idx(ins_idx), .ins_thread(ins_thread),
        .ins_bank(ins_bank), .ins_stamp(ins_stamp),
        .ret_en(ret_en), .ret_idx(ret_idx),
        .read_mode(read_mode), .qry_en(qry_en), .qry_bank(qry_bank),
        .qry_row_open(qry_row_open), .nom_take(nom_take),
        .nom_valid(nom_valid), .nom_idx(nom_idx), .nom_thread(nom_thread)
    );

    // Monitor: compare every queued expectation mid-cycle.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            cur = sb.pop_front();
            compared++;
            if (nom_valid !== cur.v ||
                (cur.v && (nom_idx !== cur.idx || nom_thread !== cur.thr))) begin
                mismatched++;
                $display("FAIL %s: got valid=%0b idx=%0d thread=%0d, expected valid=%0b idx=%0d thread=%0d",
                         cur.tag, nom_valid, nom_idx, nom_thread, cur.v, cur.idx, cur.thr);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        ins_en = 1'b0; ret_en = 1'b0; qry_en = 1'b0; nom_take = 1'b0;
        qry_row_open = 1'b0; read_mode = 1'b1;
    endtask

    task automatic ins(input logic [5:0] i, input logic [1:0] t,
                       input logic [2:0] b, input logic [15:0] s);
        ins_en = 1'b1; ins_idx = i; ins_thread = t; ins_bank = b; ins_stamp = s;
    endtask

    task automatic ret(input logic [5:0] i);
        ret_en = 1'b1; ret_idx = i;
    endtask

    task automatic query(input logic [2:0] b, input logic open, input logic mode,
                         input logic take, input logic ev, input logic [5:0] ei,
                         input logic [1:0] et, input string tag);
        exp_t e;
        qry_en = 1'b1; qry_bank = b; qry_row_open = open; read_mode = mode;
        nom_take = take;
        e.v = ev; e.idx = ei; e.thr = et; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got no completion, expected finish within 4000 cycles");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        query(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 2'd0, "R1 no nominee in reset");
        tick();
        rst_n = 1'b1;
        query(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 2'd0, "R1 no nominee after reset");
        tick(); ins(6'd5,  2'd0, 3'd2, 16'd10);
        tick(); ins(6'd6,  2'd0, 3'd3, 16'd11);
        tick(); ins(6'd9,  2'd1, 3'd2, 16'd12);
        tick(); ins(6'd20, 2'd2, 3'd4, 16'd13);
        tick(); ins(6'd21, 2'd2, 3'd2, 16'd14);
        tick(); query(3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 6'd5, 2'd0, "R2 oldest read of thread 0");
        tick(); query(3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 6'd5, 2'd0, "R12 pointer holds without take");
        tick(); query(3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 2'd0, "R3 open row blocks");
        tick(); query(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 2'd0, "R4 write mode blocks");
        tick(); query(3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 2'd0, "R11 no head on bank");
        tick(); query(3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 6'd20, 2'd2, "R2 head of thread 2");
        tick(); query(3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 6'd5, 2'd0, "R5 grant thread 0");
        tick(); query(3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 6'd9, 2'd1, "R6 busy head skipped");
        tick(); query(3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 2'd0, "R6 younger read not nominated");
        tick(); ret(6'd5);
        tick(); query(3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 6'd6, 2'd0, "R7 next-oldest becomes head");
        tick(); ret(6'd20); ins(6'd30, 2'd2, 3'd6, 16'd15);
        tick(); query(3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 6'd21, 2'd2, "R9 remaining older read wins");
        tick(); ret(6'd9); ins(6'd40, 2'd1, 3'd2, 16'd16);
        tick(); query(3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 6'd21, 2'd2, "R5 rotation starts at thread 2");
        tick(); query(3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 6'd40, 2'd1, "R10 R9 wrap to new head of thread 1");
        tick(); ret(6'd6);
        tick(); query(3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 2'd0, "R7 emptied thread has no head");
        tick(); ins(6'd50, 2'd3, 3'd1, 16'd17);
                query(3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 2'd0, "R8 not nominated while inserting");
        tick(); query(3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd50, 2'd3, "R8 first read becomes head");
        tick();
        tick();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule